// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block maps a 32-bit CPU physical address onto one of the SDRAM chip selects. Software programs a set of chip-select windows through a 32-bit register port. Each window has a base register and a size register, and an enable bit in its size register. When a lookup is presented, the decoder searches the enabled windows for the one that contains the address. One clock later it reports the window index and a per-chip-select attribute code, or it reports a miss.

Windows are aligned to 16 MiB and cover a power-of-two multiple of 16 MiB. A window whose base lies above the 4 GiB line, meaning its upper base bits are nonzero, cannot be reached by 32-bit addresses, so it never matches. When windows overlap, the lowest-numbered window wins.

Top module: `dram_cs_decoder`

## Requirements
- R1: After reset every register reads zero, so all windows are disabled. `res_valid` and `res_miss` are low, and `res_attr` is 4'hF.
- R2: The register word for window n is selected by `reg_addr[4:3]` = n. `reg_addr[2]` = 0 selects the base register and 1 selects the size register; `reg_addr[1:0]` is ignored. The base register keeps bits 31:24 (address bits 31:24) and bits 3:0 (address bits 35:32). The size register keeps bits 31:24 (size−1 in 16 MiB units), bits 4:2 (a chip-select field, stored only) and bit 0 (enable). All other bits read as zero. `reg_rdata` follows `reg_addr` combinationally.
- R3: A lookup (`lookup_valid` high) produces a result one clock later, with `res_valid` high. Back-to-back lookups produce back-to-back results.
- R4: A window whose enable bit is 0 never matches.
- R5: A window whose base bits 35:32 are nonzero never matches.
- R6: Address A hits window i when `A[31:24] & ~size[31:24]` equals `base[31:24] & ~size[31:24]`. The first address past the end of the window misses.
- R7: If several windows match, the lowest index is reported.
- R8: On a hit, `res_cs` is the window index and `res_attr` is 4'hF with bit `res_cs` cleared. On a miss, `res_miss` is high and `res_attr` is 4'hF.
- R9: In a cycle that follows no lookup, `res_valid` and `res_miss` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lookup_valid | input | 1 | Lookup request |
| lookup_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_miss | output | 1 | No enabled window matched |
| res_cs | output | 2 | Matching window index |
| res_attr | output | 4 | Active-low one-hot chip-select attribute |

## Verification
The assertions assume that `lookup_valid` is a clean single-bit strobe, sampled on each rising edge. They also assume that register writes and lookups may share a cycle, in which case the lookup sees the old register contents. The stimulus changes inputs only on falling edges. It changes windows only between lookups, so every expected result comes from a register state that has settled. Overlapping windows and windows that are disabled or placed above 4 GiB are set up on purpose, to exercise the priority and rejection paths.

// File: rtl/dram_cs_decoder.sv
module dram_cs_decoder #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [4:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic                      lookup_valid,
  input  logic [ADDR_W-1:0]         lookup_addr,
  output logic                      res_valid,
  output logic                      res_miss,
  output logic [$clog2(NUM_CS)-1:0] res_cs,
  output logic [NUM_CS-1:0]         res_attr
);
  localparam int IW = $clog2(NUM_CS);
  localparam logic [31:0] BASE_KEEP = 32'hFF00_000F;
  localparam logic [31:0] SIZE_KEEP = 32'hFF00_001D;

  logic [31:0] base_q [NUM_CS];
  logic [31:0] size_q [NUM_CS];
  logic [NUM_CS-1:0] hit;

  wire [IW-1:0] sel = reg_addr[IW+2:3];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    wire [7:0] msk = ~size_q[i][31:24];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end else if (reg_wr && sel == IW'(i)) begin
        if (reg_addr[2]) size_q[i] <= reg_wdata & SIZE_KEEP;
        else             base_q[i] <= reg_wdata & BASE_KEEP;
      end
    end
    assign hit[i] = size_q[i][0] && (base_q[i][3:0] == 4'd0) &&
                    ((lookup_addr[31:24] & msk) == (base_q[i][31:24] & msk));
  end

  assign reg_rdata = reg_addr[2] ? size_q[sel] : base_q[sel];

  logic          any_hit;
  logic [IW-1:0] win_idx;
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (!any_hit && hit[i]) begin
        any_hit = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_miss  <= 1'b0;
      res_cs    <= '0;
      res_attr  <= '1;
    end else begin
      res_valid <= lookup_valid;
      res_miss  <= lookup_valid && !any_hit;
      res_cs    <= (lookup_valid && any_hit) ? win_idx : '0;
      res_attr  <= (lookup_valid && any_hit) ? ~(NUM_CS'(1) << win_idx) : '1;
    end
  end
endmodule

// File: rtl/dram_cs_decoder_checks.sv
module dram_cs_decoder_checks #(
  parameter int NUM_CS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lookup_valid,
  input logic                      res_valid,
  input logic                      res_miss,
  input logic [$clog2(NUM_CS)-1:0] res_cs,
  input logic [NUM_CS-1:0]         res_attr
);
  a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> res_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> (!res_valid && !res_miss));
  a_r8_hit_attr: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_miss) |-> ($countones(res_attr) == NUM_CS-1 && !res_attr[res_cs]));
  a_r8_miss_attr: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_attr == '1 && res_valid));
endmodule

bind dram_cs_decoder dram_cs_decoder_checks #(.NUM_CS(NUM_CS)) u_checks (
  .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid),
  .res_valid(res_valid), .res_miss(res_miss), .res_cs(res_cs), .res_attr(res_attr));

// File: tb/dram_cs_decoder_test.sv
module dram_cs_decoder_test;
  logic        clk = 0, rst_n = 0, reg_wr = 0, lookup_valid = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, lookup_addr = 0, reg_rdata;
  logic        res_valid, res_miss;
  logic [1:0]  res_cs;
  logic [3:0]  res_attr;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] mb [4];
  logic [31:0] ms [4];

  typedef struct { logic miss; logic [1:0] cs; logic [3:0] attr; string tag; } exp_t;
  exp_t q[$];

  dram_cs_decoder uut (.*);

  always #5 clk = ~clk;

  function automatic exp_t model(logic [31:0] a, string tag);
    exp_t e;
    e.miss = 1; e.cs = 0; e.attr = 4'hF; e.tag = tag;
    for (int i = 3; i >= 0; i--) begin
      logic [7:0] m;
      m = ~ms[i][31:24];
      if (ms[i][0] && mb[i][3:0] == 0 && ((a[31:24] & m) == (mb[i][31:24] & m))) begin
        e.miss = 0; e.cs = 2'(i); e.attr = 4'hF & ~(4'(1) << i);
      end
    end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int win, bit sz, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 5'(win*8 + (sz ? 4 : 0)); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (sz) ms[win] = d & 32'hFF00_001D; else mb[win] = d & 32'hFF00_000F;
  endtask

  task automatic rd(int win, bit sz, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = 5'(win*8 + (sz ? 4 : 0)) | 5'd2;
    #1 chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic look(logic [31:0] a, string tag);
    @(negedge clk);
    lookup_valid = 1; lookup_addr = a;
    q.push_back(model(a, tag));
  endtask

  task automatic idle(int n);
    @(negedge clk);
    lookup_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n && !done) begin
    if (res_valid) begin
      if (q.size() == 0) chk(0, "R3 unexpected result", 32'(res_valid), 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(res_miss == e.miss && res_attr == e.attr && (e.miss || res_cs == e.cs),
            e.tag, {23'd0, res_miss, 2'd0, res_cs, res_attr},
            {23'd0, e.miss, 2'd0, e.cs, e.attr});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mb[i] = 0; ms[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(i, 0, 0, "R1 base reset");
      rd(i, 1, 0, "R1 size reset");
    end
    chk(!res_valid && !res_miss && res_attr == 4'hF, "R1 outputs",
        {res_valid, res_miss, res_attr}, {2'b00, 4'hF});
    // R2 field masking
    wr(0, 0, 32'hFFFF_FFFF); rd(0, 0, 32'hFF00_000F, "R2 base mask");
    wr(0, 1, 32'hFFFF_FFFF); rd(0, 1, 32'hFF00_001D, "R2 size mask");
    wr(3, 1, 32'h1234_5678); rd(3, 1, 32'h1200_0018, "R2 size win3");
    // setup
    wr(0, 0, 32'h0000_0000); wr(0, 1, 32'h0300_0001);
    wr(1, 0, 32'h4000_0000); wr(1, 1, 32'h0F00_0005);
    wr(2, 0, 32'h8000_0000); wr(2, 1, 32'h1F00_0008);
    wr(3, 0, 32'hC000_0001); wr(3, 1, 32'h3F00_000D);
    rd(3, 0, 32'hC000_0001, "R2 base high bits");
    // back-to-back lookups
    look(32'h0000_0000, "R3 R8 win0 low");
    look(32'h03FF_FFFF, "R6 win0 top");
    look(32'h0400_0000, "R6 past end");
    look(32'h4000_0000, "R8 win1 base");
    look(32'h4FFF_FFFF, "R6 win1 top");
    look(32'h5000_0000, "R6 win1 past end");
    look(32'h8000_1234, "R4 disabled");
    look(32'hC000_0000, "R5 high base");
    idle(2);
    chk(!res_valid && !res_miss, "R9 idle", {res_valid, res_miss}, 0);
    wr(2, 1, 32'h1F00_0009);
    wr(3, 0, 32'hC000_0000);
    look(32'h9F00_0000, "R8 win2 enabled");
    look(32'hC100_0000, "R5 R8 win3 fixed");
    look(32'hFFFF_FFFF, "R8 win3 top");
    idle(2);
    // overlap: win2 over win1 range
    wr(2, 0, 32'h4000_0000); wr(2, 1, 32'h1F00_0009);
    look(32'h4100_0000, "R7 overlap low index");
    look(32'h5800_0000, "R7 only win2");
    idle(1);
    wr(1, 1, 32'h0F00_0004);
    look(32'h4100_0000, "R4 R7 win1 disabled");
    idle(2);
    chk(q.size() == 0, "R3 all results seen", 32'(q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule